// File: doc/BRIEF.md
# Per-Cycle Activity-Driven Power Estimator

This block watches one logic block and produces a fresh power estimate on every clock cycle. It samples three vectors each cycle: the block's monitored inputs, the enables of its local clock buffers, and a set of global nets. From these it derives three fractions. The switching factor is the share of monitored inputs that changed since the last cycle. The clock activity is the load-weighted share of buffers that are enabled. The net toggle fraction is the share of global nets that changed.

The estimate comes from a linear macro model. The model is characterised at two switching-factor points, 0 % and 50 %, and at two clock states, fully off and fully on. The block first finds the clock-off and clock-on power at the current switching factor. It then interpolates between those two values using the clock activity, and adds a net term scaled by the net toggle fraction.

A small write port loads the model coefficients, the buffer weights and the reciprocal of the total weight. The power word leaves the block after two pipeline stages, together with a valid flag. A saturating energy accumulator sums the power words and can be cleared synchronously.

Top module: `pwr_estimator`

## Requirements
- R1: The switching factor is floor(t·65536/N_IN), where t is the number of bits of `inVec` that differ from the previous cycle's sample. The first sample after reset uses a switching factor of 0. The net toggle fraction is formed the same way from `netVec` over N_NET bits.
- R2: Clock activity is Q16 and is computed as min(65536, floor(S·recip/65536)). S is the sum of the weights of the buffers whose `bufEn` bit is 1, and recip is the programmed reciprocal. When all weights sum to 0, clock activity is 0.
- R3: A write with `cfgWe`=1 takes effect at the clock edge. The address map is: 0 = clock-off power at SF 0, 1 = clock-off power at SF 50 %, 2 = clock-on power at SF 0, 3 = clock-on power at SF 50 %, 4 = net coefficient, 5 = reciprocal (32 bits), 8+i = weight of buffer i. Coefficients and weights take the low bits of `cfgData`. Writes to any other address change nothing. After reset every weight is DEF_WGT and the reciprocal is floor(2^32/(N_BUF·DEF_WGT)).
- R4: Each clock-state curve is evaluated as P = lo + floor((hi − lo)·2·SF/65536), where lo is the coefficient at SF 0 and hi the coefficient at SF 50 %. A negative slope extrapolates downward. The result is clamped to [0, 2^PWR_W − 1].
- R5: Macro power is Poff + floor((Pon − Poff)·CLK/65536).
- R6: The net term is floor(netCoef·NF/65536) and is added to the macro power.
- R7: The power word saturates at 2^PWR_W − 1.
- R8: Inputs sampled at edge k produce `powerOut` at edge k+1. `powerValid` rises with the first result after reset and then stays high. A new result appears every cycle, with no averaging.
- R9: At each edge that produces a valid result, `energyAcc` adds that result and saturates at 2^ACC_W − 1. When `energyClr` is 1 at an edge, `energyAcc` becomes 0 instead.
- R10: Reset (synchronous, active high) sets `powerOut`, `powerValid` and `energyAcc` to 0. `powerOut` stays 0 until `powerValid` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inVec | input | N_IN | Monitored block inputs |
| bufEn | input | N_BUF | Local clock-buffer enables |
| netVec | input | N_NET | Monitored global nets |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | CFG_AW | Configuration address |
| cfgData | input | 32 | Configuration write data |
| energyClr | input | 1 | Synchronous clear of the energy accumulator |
| powerOut | output | PWR_W | Per-cycle power estimate |
| powerValid | output | 1 | Power estimate valid |
| energyAcc | output | ACC_W | Saturating energy sum |

## Verification
Three situations are hard to reach from random stimulus alone. The first is negative extrapolation that must clamp at zero. The second is a weight-times-reciprocal product that overshoots 1.0. The third is an energy sum that sits at its ceiling. The bench steers into each one with directed programming: a 50 % coefficient below half the 0 % coefficient, an oversized weight, and maximum coefficients held for long runs. It also builds the bench instance with narrow power and energy widths, so that saturation is reached within a few hundred cycles.

// File: rtl/pwrest_pkg.sv
package pwrest_pkg;

  // Q16 unsigned fixed point for every fraction
  localparam int FRAC = 16;
  localparam longint ONE_Q = longint'(1) <<< FRAC;

  typedef struct packed {
    logic firstSmp;  // no previous sample: force toggle fractions to zero
    logic ldOut;     // stage-1 holds a real sample, load the output stage
    logic accClr;    // clear the energy sum this edge
    logic accAdd;    // add the new power word into the energy sum
  } pe_ctrl_t;

  function automatic longint clampRange(longint v, longint hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/pwrest_cfg.sv
module pwrest_cfg #(
  parameter int N_BUF   = 4,
  parameter int WGT_W   = 8,
  parameter int DEF_WGT = 8,
  parameter int COEF_W  = 16,
  parameter int CFG_AW  = 4,
  localparam int SUMW   = WGT_W + $clog2(N_BUF + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgData,
  output logic [COEF_W-1:0] offLow,
  output logic [COEF_W-1:0] offHalf,
  output logic [COEF_W-1:0] onLow,
  output logic [COEF_W-1:0] onHalf,
  output logic [COEF_W-1:0] netCoef,
  output logic [31:0]       recip,
  output logic [WGT_W-1:0]  wgt [N_BUF],
  output logic [SUMW-1:0]   totWgt
);

  localparam int WBASE = 1 << (CFG_AW - 1);
  localparam int DEF_TOT = (N_BUF * DEF_WGT < 1) ? 1 : N_BUF * DEF_WGT;
  localparam longint RDEF = (longint'(1) <<< 32) / longint'(DEF_TOT);

  function automatic logic hit(input logic [CFG_AW-1:0] a, input int idx);
    return a == CFG_AW'(idx);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      offLow  <= '0;
      offHalf <= '0;
      onLow   <= '0;
      onHalf  <= '0;
      netCoef <= '0;
      recip   <= 32'(RDEF);
    end else if (cfgWe) begin
      if (hit(cfgAddr, 0)) offLow  <= cfgData[COEF_W-1:0];
      if (hit(cfgAddr, 1)) offHalf <= cfgData[COEF_W-1:0];
      if (hit(cfgAddr, 2)) onLow   <= cfgData[COEF_W-1:0];
      if (hit(cfgAddr, 3)) onHalf  <= cfgData[COEF_W-1:0];
      if (hit(cfgAddr, 4)) netCoef <= cfgData[COEF_W-1:0];
      if (hit(cfgAddr, 5)) recip   <= cfgData;
    end
  end

  for (genvar i = 0; i < N_BUF; i++) begin : g_wgt
    always_ff @(posedge clk) begin
      if (rst) begin
        wgt[i] <= WGT_W'(DEF_WGT);
      end else if (cfgWe && hit(cfgAddr, WBASE + i)) begin
        wgt[i] <= cfgData[WGT_W-1:0];
      end
    end
  end

  always_comb begin
    totWgt = '0;
    for (int i = 0; i < N_BUF; i++) begin
      totWgt = totWgt + SUMW'(wgt[i]);
    end
  end

endmodule

// File: rtl/pwrest_ctrl.sv
module pwrest_ctrl
  import pwrest_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     energyClr,
  output pe_ctrl_t strobes,
  output logic     outValid
);

  logic firstR;
  logic stage1Valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      firstR      <= 1'b1;
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      firstR      <= 1'b0;
      stage1Valid <= 1'b1;
      outValid    <= stage1Valid;
    end
  end

  always_comb begin
    strobes.firstSmp = firstR;
    strobes.ldOut    = stage1Valid;
    strobes.accClr   = energyClr;
    strobes.accAdd   = stage1Valid & ~energyClr;
  end

endmodule

// File: rtl/pwrest_dp.sv
module pwrest_dp
  import pwrest_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_BUF  = 4,
  parameter int N_NET  = 8,
  parameter int WGT_W  = 8,
  parameter int COEF_W = 16,
  parameter int PWR_W  = 24,
  parameter int ACC_W  = 48,
  localparam int SUMW  = WGT_W + $clog2(N_BUF + 1),
  localparam int FR1   = FRAC + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  pe_ctrl_t          st,
  input  logic [N_IN-1:0]   inVec,
  input  logic [N_BUF-1:0]  bufEn,
  input  logic [N_NET-1:0]  netVec,
  input  logic [COEF_W-1:0] offLow,
  input  logic [COEF_W-1:0] offHalf,
  input  logic [COEF_W-1:0] onLow,
  input  logic [COEF_W-1:0] onHalf,
  input  logic [COEF_W-1:0] netCoef,
  input  logic [31:0]       recip,
  input  logic [WGT_W-1:0]  wgt [N_BUF],
  input  logic [SUMW-1:0]   totWgt,
  output logic [PWR_W-1:0]  powerOut,
  output logic [ACC_W-1:0]  energyAcc
);

  localparam longint PMAX = (longint'(1) <<< PWR_W) - 1;
  localparam longint AMAX = (longint'(1) <<< ACC_W) - 1;

  // stage 1: activity fractions
  logic [N_IN-1:0]  prevIn;
  logic [N_NET-1:0] prevNet;
  logic [FR1-1:0]   sfR, nfR, clkR;
  logic [FR1-1:0]   sfNext, nfNext, clkNext;
  logic [SUMW-1:0]  enWgt;
  longint           clkProd;

  always_comb begin
    enWgt = '0;
    for (int i = 0; i < N_BUF; i++) begin
      if (bufEn[i]) enWgt = enWgt + SUMW'(wgt[i]);
    end
    clkProd = (longint'(enWgt) * longint'(recip)) >>> FRAC;
    if (totWgt == '0) clkNext = '0;
    else if (clkProd > ONE_Q) clkNext = FR1'(ONE_Q);
    else clkNext = FR1'(clkProd);

    if (st.firstSmp) begin
      sfNext = '0;
      nfNext = '0;
    end else begin
      sfNext = FR1'((longint'($countones(inVec ^ prevIn)) <<< FRAC) / longint'(N_IN));
      nfNext = FR1'((longint'($countones(netVec ^ prevNet)) <<< FRAC) / longint'(N_NET));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevIn  <= '0;
      prevNet <= '0;
      sfR     <= '0;
      nfR     <= '0;
      clkR    <= '0;
    end else begin
      prevIn  <= inVec;
      prevNet <= netVec;
      sfR     <= sfNext;
      nfR     <= nfNext;
      clkR    <= clkNext;
    end
  end

  // stage 2: model evaluation
  longint offV, onV, macroV, netV, eSum;
  logic [PWR_W-1:0] powNext;
  logic [ACC_W-1:0] eNext;

  function automatic longint curve(input logic [COEF_W-1:0] lo,
                                   input logic [COEF_W-1:0] hi,
                                   input logic [FR1-1:0] sf);
    longint slope;
    slope = longint'(hi) - longint'(lo);
    return clampRange(longint'(lo) + ((slope * longint'(sf) * 2) >>> FRAC), PMAX);
  endfunction

  always_comb begin
    offV    = curve(offLow, offHalf, sfR);
    onV     = curve(onLow, onHalf, sfR);
    macroV  = offV + (((onV - offV) * longint'(clkR)) >>> FRAC);
    netV    = (longint'(netCoef) * longint'(nfR)) >>> FRAC;
    powNext = PWR_W'(clampRange(macroV + netV, PMAX));
    eSum    = longint'(energyAcc) + longint'(powNext);
    if (st.accClr) eNext = '0;
    else if (st.accAdd) eNext = ACC_W'(clampRange(eSum, AMAX));
    else eNext = energyAcc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      powerOut  <= '0;
      energyAcc <= '0;
    end else begin
      if (st.ldOut) powerOut <= powNext;
      energyAcc <= eNext;
    end
  end

endmodule

// File: rtl/pwr_estimator.sv
module pwr_estimator
  import pwrest_pkg::*;
#(
  parameter int N_IN    = 16,
  parameter int N_BUF   = 4,
  parameter int N_NET   = 8,
  parameter int WGT_W   = 8,
  parameter int DEF_WGT = 8,
  parameter int COEF_W  = 16,
  parameter int PWR_W   = 24,
  parameter int ACC_W   = 48,
  parameter int CFG_AW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   inVec,
  input  logic [N_BUF-1:0]  bufEn,
  input  logic [N_NET-1:0]  netVec,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgData,
  input  logic              energyClr,
  output logic [PWR_W-1:0]  powerOut,
  output logic              powerValid,
  output logic [ACC_W-1:0]  energyAcc
);

  localparam int SUMW = WGT_W + $clog2(N_BUF + 1);

  pe_ctrl_t          strobes;
  logic [COEF_W-1:0] offLow, offHalf, onLow, onHalf, netCoef;
  logic [31:0]       recip;
  logic [WGT_W-1:0]  wgt [N_BUF];
  logic [SUMW-1:0]   totWgt;

  pwrest_cfg #(
    .N_BUF(N_BUF), .WGT_W(WGT_W), .DEF_WGT(DEF_WGT),
    .COEF_W(COEF_W), .CFG_AW(CFG_AW)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .offLow(offLow), .offHalf(offHalf), .onLow(onLow), .onHalf(onHalf),
    .netCoef(netCoef), .recip(recip), .wgt(wgt), .totWgt(totWgt)
  );

  pwrest_ctrl u_ctrl (
    .clk(clk), .rst(rst), .energyClr(energyClr),
    .strobes(strobes), .outValid(powerValid)
  );

  pwrest_dp #(
    .N_IN(N_IN), .N_BUF(N_BUF), .N_NET(N_NET), .WGT_W(WGT_W),
    .COEF_W(COEF_W), .PWR_W(PWR_W), .ACC_W(ACC_W)
  ) u_dp (
    .clk(clk), .rst(rst), .st(strobes),
    .inVec(inVec), .bufEn(bufEn), .netVec(netVec),
    .offLow(offLow), .offHalf(offHalf), .onLow(onLow), .onHalf(onHalf),
    .netCoef(netCoef), .recip(recip), .wgt(wgt), .totWgt(totWgt),
    .powerOut(powerOut), .energyAcc(energyAcc)
  );

endmodule

// File: rtl/pwr_estimator_chk.sv
module pwr_estimator_chk #(
  parameter int PWR_W = 24,
  parameter int ACC_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             energyClr,
  input logic             powerValid,
  input logic [PWR_W-1:0] powerOut,
  input logic [ACC_W-1:0] energyAcc
);

  localparam logic [ACC_W:0] AMAX = {1'b0, {ACC_W{1'b1}}};

  logic [ACC_W-1:0] prevE;
  logic [ACC_W:0]   rawSum;
  logic [ACC_W-1:0] satSum;

  always_ff @(posedge clk) prevE <= energyAcc;

  always_comb begin
    rawSum = {1'b0, prevE} + (ACC_W + 1)'(powerOut);
    satSum = (rawSum > AMAX) ? ACC_W'(AMAX) : ACC_W'(rawSum);
  end

  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    powerValid |=> powerValid);

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !powerValid |-> (powerOut == '0));

  // R9
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    energyClr |=> (energyAcc == '0));

  // R9
  acc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !energyClr |=> (!powerValid || energyAcc == satSum));

  // R9
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !energyClr |=> (powerValid || $stable(energyAcc)));

endmodule

bind pwr_estimator pwr_estimator_chk #(.PWR_W(PWR_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .energyClr(energyClr), .powerValid(powerValid),
  .powerOut(powerOut), .energyAcc(energyAcc)
);

// File: tb/pwr_estimator_bench.sv
module pwr_estimator_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 16, N_BUF = 4, N_NET = 8, WGT_W = 8, DEF_WGT = 8;
  localparam int COEF_W = 16, PWR_W = 17, ACC_W = 24, CFG_AW = 4;
  localparam longint PMAX = (longint'(1) <<< PWR_W) - 1;
  localparam longint AMAX = (longint'(1) <<< ACC_W) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [N_IN-1:0] inVec = '0;
  logic [N_BUF-1:0] bufEn = '0;
  logic [N_NET-1:0] netVec = '0;
  logic cfgWe = 1'b0;
  logic [CFG_AW-1:0] cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic energyClr = 1'b0;
  logic [PWR_W-1:0] powerOut;
  logic powerValid;
  logic [ACC_W-1:0] energyAcc;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwr_estimator #(
    .N_IN(N_IN), .N_BUF(N_BUF), .N_NET(N_NET), .WGT_W(WGT_W), .DEF_WGT(DEF_WGT),
    .COEF_W(COEF_W), .PWR_W(PWR_W), .ACC_W(ACC_W), .CFG_AW(CFG_AW)
  ) u_pwr_estimator (.*);

  // shadow configuration
  longint sLo0 = 0, sHf0 = 0, sLo1 = 0, sHf1 = 0, sNet = 0;
  longint sRecip = (longint'(1) <<< 32) / (N_BUF * DEF_WGT);
  longint sW [N_BUF];

  logic [N_IN-1:0] px = '0;
  logic [N_NET-1:0] pn = '0;
  bit firstS = 1'b1, e1V = 1'b0, e2V = 1'b0, clrLast = 1'b0;
  longint e1P = 0, e2P = 0, expE = 0;
  int skip = 0, nChk = 0, nErr = 0;

  function automatic longint sat(longint v, longint hi);
    return (v < 0) ? 0 : ((v > hi) ? hi : v);
  endfunction

  function automatic longint model(logic [N_IN-1:0] x, logic [N_IN-1:0] xp,
                                   logic [N_BUF-1:0] en,
                                   logic [N_NET-1:0] n, logic [N_NET-1:0] np,
                                   bit first);
    longint sf, nf, ws, tot, ca, pOff, pOn, mac;
    sf = first ? 0 : (longint'($countones(x ^ xp)) * 65536) / N_IN;
    nf = first ? 0 : (longint'($countones(n ^ np)) * 65536) / N_NET;
    ws = 0; tot = 0;
    for (int i = 0; i < N_BUF; i++) begin
      tot += sW[i];
      if (en[i]) ws += sW[i];
    end
    ca = (tot == 0) ? 0 : sat((ws * sRecip) >>> 16, 65536);
    pOff = sat(sLo0 + (((sHf0 - sLo0) * sf * 2) >>> 16), PMAX);
    pOn  = sat(sLo1 + (((sHf1 - sLo1) * sf * 2) >>> 16), PMAX);
    mac = pOff + (((pOn - pOff) * ca) >>> 16);
    return sat(mac + ((sNet * nf) >>> 16), PMAX);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(logic [N_IN-1:0] x, logic [N_BUF-1:0] en, logic [N_NET-1:0] n,
                      bit we, logic [CFG_AW-1:0] a, logic [31:0] d, bit clr, string tag);
    if (clrLast) expE = 0;
    else if (e2V) expE = sat(expE + e2P, AMAX);
    if (skip > 0) skip--;
    else begin
      chk(powerValid == e2V, {tag, " R8 valid"}, powerValid, e2V);
      if (e2V) chk(powerOut == e2P, {tag, " power"}, powerOut, e2P);
      else chk(powerOut == 0, {tag, " R10 idle power"}, powerOut, 0);
      chk(energyAcc == expE, {tag, " R9 energy"}, energyAcc, expE);
    end
    e2P = e1P; e2V = e1V;
    if (we) begin
      case (a)
        0: sLo0 = d[15:0];
        1: sHf0 = d[15:0];
        2: sLo1 = d[15:0];
        3: sHf1 = d[15:0];
        4: sNet = d[15:0];
        5: sRecip = d;
        8, 9, 10, 11: sW[a - 8] = d[7:0];
        default: ;
      endcase
      skip = 2;
    end
    e1P = model(x, px, en, n, pn, firstS);
    e1V = 1'b1; firstS = 1'b0; px = x; pn = n;
    inVec = x; bufEn = en; netVec = n;
    cfgWe = we; cfgAddr = a; cfgData = d;
    energyClr = clr || (skip > 0);
    clrLast = energyClr;
    @(negedge clk);
  endtask

  task automatic wr(logic [CFG_AW-1:0] a, logic [31:0] d, string tag);
    step(px, '0, pn, 1'b1, a, d, 1'b0, tag);
  endtask

  task automatic run(int cnt, logic [N_IN-1:0] x, logic [N_BUF-1:0] en,
                     logic [N_NET-1:0] n, bit tog, string tag);
    logic [N_IN-1:0] xv = x;
    logic [N_NET-1:0] nv = n;
    for (int i = 0; i < cnt; i++) begin
      if (tog) begin xv = ~xv; nv = ~nv; end
      step(xv, en, nv, 1'b0, '0, '0, 1'b0, tag);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < N_BUF; i++) sW[i] = DEF_WGT;
    void'($urandom(32'd20231));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(powerOut == 0, "R10 reset power", powerOut, 0);
    chk(powerValid == 0, "R10 reset valid", powerValid, 0);
    chk(energyAcc == 0, "R10 reset energy", energyAcc, 0);
    rst = 1'b0;

    // R3 program model
    wr(0, 100, "R3 cfg"); wr(1, 300, "R3 cfg"); wr(2, 500, "R3 cfg");
    wr(3, 1500, "R3 cfg"); wr(4, 2000, "R3 cfg");
    // R1 R5 no toggle, all buffers off: expect 100
    run(5, 16'hA5A5, 4'b0000, 8'h3C, 1'b0, "R1 R5 no-toggle all-off");
    chk(powerOut == 100, "R1 R5 no-toggle all-off direct", powerOut, 100);
    // R2 R5 all on: expect 500
    run(4, 16'hA5A5, 4'b1111, 8'h3C, 1'b0, "R2 R5 all-on");
    chk(powerOut == 500, "R2 R5 all-on direct", powerOut, 500);
    // R4 R6 full toggle, all on: 2500 + 2000
    run(4, 16'hA5A5, 4'b1111, 8'h3C, 1'b1, "R4 R6 full toggle");
    chk(powerOut == 4500, "R4 R6 full toggle direct", powerOut, 4500);
    // R2 weighted half: 100 + 400/2 = 300
    run(4, px, 4'b0011, pn, 1'b0, "R2 half load");
    chk(powerOut == 300, "R2 half load direct", powerOut, 300);
    // R3 unmapped addresses ignored
    wr(6, 32'h0000_3039, "R3 unmapped"); wr(15, 32'h0000_0007, "R3 unmapped");
    run(4, px, 4'b0011, pn, 1'b0, "R3 unmapped");
    chk(powerOut == 300, "R3 unmapped direct", powerOut, 300);
    // R2 clamp of clock activity at 1.0
    wr(8, 200, "R2 clk sat");
    run(4, px, 4'b0001, pn, 1'b0, "R2 clk sat");
    chk(powerOut == 500, "R2 clk sat direct", powerOut, 500);
    // R2 zero total weight
    for (int i = 0; i < N_BUF; i++) wr(CFG_AW'(8 + i), 0, "R2 zero total");
    run(4, px, 4'b1111, pn, 1'b0, "R2 zero total");
    chk(powerOut == 100, "R2 zero total direct", powerOut, 100);
    for (int i = 0; i < N_BUF; i++) wr(CFG_AW'(8 + i), DEF_WGT, "R3 restore");
    // R4 negative extrapolation clamps to zero
    wr(0, 1000, "R4 clamp"); wr(1, 100, "R4 clamp");
    run(4, px, 4'b0000, pn, 1'b0, "R4 clamp");
    for (int i = 0; i < 4; i++) step(~px, 4'b0000, pn, 1'b0, '0, '0, 1'b0, "R4 clamp");
    chk(powerOut == 0, "R4 clamp direct", powerOut, 0);
    // R7 R9 saturation of power and energy
    wr(2, 0, "R7 sat"); wr(3, 65535, "R7 sat"); wr(4, 65535, "R7 sat");
    run(150, px, 4'b1111, pn, 1'b1, "R7 R9 saturate");
    chk(powerOut == PMAX, "R7 power saturate direct", powerOut, PMAX);
    chk(energyAcc == AMAX, "R9 energy saturate direct", energyAcc, AMAX);
    // R9 clear
    step(px, 4'b1111, pn, 1'b0, '0, '0, 1'b1, "R9 clear");
    run(3, px, 4'b0000, pn, 1'b0, "R9 clear");

    // constrained random: R1 R2 R4 R5 R6 R7 R8 R9
    for (int it = 0; it < 3000; it++) begin
      if (it % 97 == 50) begin
        logic [CFG_AW-1:0] a = CFG_AW'($urandom_range(0, 15));
        logic [31:0] d = (a == 5) ? 32'($urandom_range(0, 1 << 28)) : 32'($urandom);
        wr(a, d, "rand cfg R3");
      end else begin
        logic [N_IN-1:0] x = ($urandom_range(0, 7) == 0) ? px : N_IN'($urandom);
        step(x, N_BUF'($urandom), N_NET'($urandom), 1'b0, '0, '0,
             ($urandom_range(0, 49) == 0), "rand R1 R2 R4 R5 R6 R7");
      end
    end
    finishRun();
  end

endmodule